// File: doc/BRIEF.md
# Timer Interrupt Level Arbiter

This block gathers interrupt requests from up to thirteen numbered timer sources and presents them to a system bus as seven level-coded request lines. Each source has its own programmable request level and a private arbitration bit. One shared configuration register supplies the three upper bits of the arbitration number and the two upper bits of the returned vector.

When the bus runs an interrupt acknowledge cycle, it presents the level and the 4-bit arbitration number it is serving. The block looks for pending sources that match both values. If several match, the lowest-numbered source wins. The block then returns an 8-bit vector made of the two shared upper bits and the winner's 6-bit index. It also sends a one-cycle acknowledge pulse to the winning source, which clears its own pending flag. The block never clears a request itself.

Top module: `irq_level_arbiter`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq_lines`, `iack_hit`, `iack_vector` and `src_ack` are all zero, and both configuration fields hold zero.
- R2: One clock after the inputs, bit k of `irq_lines` is 1 exactly when some source i is pending, is allowed to request, and has a level field equal to k+1. Only sources 2 to 12 may request; sources 0 and 1 never do. A level field of 0 disables the source.
- R3: On a clock where `cfg_we` is high, the shared arbitration field takes `cfg_arb_hi` and the shared vector field takes `cfg_vec_hi`. Both are used from the next clock on.
- R4: A source i matches an acknowledge when all of the following hold:
  - `iack_valid` is high;
  - the source is pending and allowed to request;
  - its level field is nonzero and equals `iack_level`;
  - `iack_arb` equals the shared field in bits 3:1 joined with `src_arb[i]` in bit 0.
- R5: When several sources match, the one with the lowest index wins.
- R6: On a hit, `iack_vector` carries the shared vector field in bits 7:6 and the winner's index in bits 5:0.
- R7: On a hit, `src_ack` has exactly the winner's bit set. When there is no hit, `iack_hit` is 0, `src_ack` is all zero and `iack_vector` is zero.
- R8: While the shared arbitration field is zero, no acknowledge produces a hit.
- R9: `iack_hit`, `iack_vector` and `src_ack` are registered. They reflect the acknowledge sampled on the previous clock and are high for that one cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pend | input | 13 | Pending flag for each source |
| src_level | input | 39 | 3-bit level field for each source; source i uses bits 3i+2:3i |
| src_arb | input | 13 | Private arbitration bit for each source |
| cfg_we | input | 1 | Write strobe for the shared configuration register |
| cfg_arb_hi | input | 3 | New value for the shared arbitration bits |
| cfg_vec_hi | input | 2 | New value for the shared vector bits |
| iack_valid | input | 1 | An acknowledge cycle is being served |
| iack_level | input | 3 | Level being acknowledged |
| iack_arb | input | 4 | Arbitration number being acknowledged |
| irq_lines | output | 7 | Request lines; bit k stands for level k+1 |
| iack_hit | output | 1 | The block answered the acknowledge |
| iack_vector | output | 8 | Returned vector |
| src_ack | output | 13 | One-hot acknowledge pulse to the winning source |

## Verification
The assertions assume that the sources hold their pending flags and fields steady for a whole clock. They also assume that a winning source is free to keep its flag set after being acknowledged, because the block draws no conclusion from that.

The stimulus changes pending flags, levels and arbitration bits only between acknowledges. About half of the acknowledges are aimed at a randomly chosen source's level and arbitration number, so that hits, ties and near misses all occur. The remaining acknowledges use random level and arbitration values, which mostly miss.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W   = 3;
  localparam int NUM_LVL = (1 << LVL_W) - 1;
  localparam int ARBH_W  = 3;
  localparam int ARB_W   = ARBH_W + 1;
  localparam int IDX_W   = 6;
  localparam int VECH_W  = 2;
  localparam int VEC_W   = VECH_W + IDX_W;

  typedef struct packed {
    logic [ARBH_W-1:0] arb_hi;
    logic [VECH_W-1:0] vec_hi;
  } arb_cfg_t;
endpackage

// File: rtl/irq_line_encoder.sv
module irq_line_encoder
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC = 13,
  parameter logic [NUM_SRC-1:0] CAN_REQ = 13'h1FFC
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         pend,
  input  logic [NUM_SRC*LVL_W-1:0]   level_flat,
  output logic [NUM_LVL-1:0]         lines_q
);
  logic [NUM_LVL-1:0] lines_d;

  for (genvar k = 0; k < NUM_LVL; k++) begin : g_line
    always_comb begin
      lines_d[k] = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        if (CAN_REQ[i] && pend[i] &&
            level_flat[i*LVL_W +: LVL_W] == LVL_W'(k + 1))
          lines_d[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= lines_d;
  end

  AST_LINE_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    (lines_q != '0) |-> ($past(pend & CAN_REQ) != '0)); // R2
endmodule

// File: rtl/irq_match_prio.sv
module irq_match_prio
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC = 13,
  parameter logic [NUM_SRC-1:0] CAN_REQ = 13'h1FFC
) (
  input  logic [NUM_SRC-1:0]       pend,
  input  logic [NUM_SRC*LVL_W-1:0] level_flat,
  input  logic [NUM_SRC-1:0]       arb_bit,
  input  logic [ARBH_W-1:0]        arb_hi,
  input  logic [LVL_W-1:0]         ack_level,
  input  logic [ARB_W-1:0]         ack_arb,
  output logic                     found,
  output logic [IDX_W-1:0]         win_idx,
  output logic [NUM_SRC-1:0]       win_onehot
);
  logic [NUM_SRC-1:0] match;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
    if (CAN_REQ[i]) begin : g_on
      logic [LVL_W-1:0] lv;
      assign lv = level_flat[i*LVL_W +: LVL_W];
      assign match[i] = pend[i] && (lv != '0) && (lv == ack_level) &&
                        (arb_hi != '0) && (ack_arb == {arb_hi, arb_bit[i]});
    end else begin : g_off
      assign match[i] = 1'b0;
    end
  end

  always_comb begin
    found      = 1'b0;
    win_idx    = '0;
    win_onehot = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (match[i]) begin
        found         = 1'b1;
        win_idx       = IDX_W'(i);
        win_onehot    = '0;
        win_onehot[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_level_arbiter.sv
module irq_level_arbiter
  import irq_arb_pkg::*;
#(
  parameter int          NUM_SRC = 13,
  parameter logic [NUM_SRC-1:0] CAN_REQ = 13'h1FFC
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_SRC-1:0]         src_pend,
  input  logic [NUM_SRC*LVL_W-1:0]   src_level,
  input  logic [NUM_SRC-1:0]         src_arb,
  input  logic                       cfg_we,
  input  logic [ARBH_W-1:0]          cfg_arb_hi,
  input  logic [VECH_W-1:0]          cfg_vec_hi,
  input  logic                       iack_valid,
  input  logic [LVL_W-1:0]           iack_level,
  input  logic [ARB_W-1:0]           iack_arb,
  output logic [NUM_LVL-1:0]         irq_lines,
  output logic                       iack_hit,
  output logic [VEC_W-1:0]           iack_vector,
  output logic [NUM_SRC-1:0]         src_ack
);
  arb_cfg_t           cfg_q;
  logic               found;
  logic [IDX_W-1:0]   win_idx;
  logic [NUM_SRC-1:0] win_oh;
  logic               take;

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_we) cfg_q <= '{arb_hi: cfg_arb_hi, vec_hi: cfg_vec_hi};
  end

  irq_line_encoder #(.NUM_SRC(NUM_SRC), .CAN_REQ(CAN_REQ)) u_lines (
    .clk(clk), .rst(rst), .pend(src_pend), .level_flat(src_level),
    .lines_q(irq_lines)
  );

  irq_match_prio #(.NUM_SRC(NUM_SRC), .CAN_REQ(CAN_REQ)) u_prio (
    .pend(src_pend), .level_flat(src_level), .arb_bit(src_arb),
    .arb_hi(cfg_q.arb_hi), .ack_level(iack_level), .ack_arb(iack_arb),
    .found(found), .win_idx(win_idx), .win_onehot(win_oh)
  );

  assign take = iack_valid && found;

  always_ff @(posedge clk) begin
    if (rst || !take) begin
      iack_hit    <= 1'b0;
      iack_vector <= '0;
      src_ack     <= '0;
    end else begin
      iack_hit    <= 1'b1;
      iack_vector <= {cfg_q.vec_hi, win_idx};
      src_ack     <= win_oh;
    end
  end

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(src_ack)); // R7
  AST_HIT_HAS_ACK: assert property (@(posedge clk) disable iff (rst)
    iack_hit |-> ($countones(src_ack) == 1)); // R7
  AST_HIT_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
    !iack_valid |=> !iack_hit); // R9
  AST_ZERO_ARB_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.arb_hi == '0) |=> !iack_hit); // R8
  AST_VEC_UPPER: assert property (@(posedge clk) disable iff (rst)
    (iack_hit && !$past(cfg_we)) |-> (iack_vector[VEC_W-1:IDX_W] == cfg_q.vec_hi)); // R6
  AST_ACK_PENDING: assert property (@(posedge clk) disable iff (rst)
    iack_hit |-> (($past(src_pend) & src_ack) != '0)); // R4
endmodule

// File: tb/irq_level_arbiter_tb.sv
module irq_level_arbiter_tb;
  localparam int CLK_P = 10;
  localparam int N = 13;
  localparam logic [N-1:0] MASK = 13'h1FFC;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] pend, arb;
  logic [N*3-1:0] lvl;
  logic cfg_we;
  logic [2:0] cfg_arb_hi;
  logic [1:0] cfg_vec_hi;
  logic iv;
  logic [2:0] il;
  logic [3:0] ia;
  logic [6:0] lines;
  logic hit;
  logic [7:0] vec;
  logic [N-1:0] ack;

  int nchk = 0, nfail = 0;
  logic [2:0] m_arb_hi = '0;
  logic [1:0] m_vec_hi = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_level_arbiter u_dut (
    .clk(clk), .rst(rst), .src_pend(pend), .src_level(lvl), .src_arb(arb),
    .cfg_we(cfg_we), .cfg_arb_hi(cfg_arb_hi), .cfg_vec_hi(cfg_vec_hi),
    .iack_valid(iv), .iack_level(il), .iack_arb(ia),
    .irq_lines(lines), .iack_hit(hit), .iack_vector(vec), .src_ack(ack)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [6:0] exp_lines();
    logic [6:0] r = '0;
    for (int i = 0; i < N; i++)
      if (MASK[i] && pend[i] && lvl[i*3 +: 3] != 3'd0) r[lvl[i*3 +: 3] - 1] = 1'b1;
    return r;
  endfunction

  function automatic int exp_win();
    if (!iv || m_arb_hi == 3'd0) return -1;
    for (int i = 0; i < N; i++)
      if (MASK[i] && pend[i] && lvl[i*3 +: 3] != 3'd0 && lvl[i*3 +: 3] == il &&
          ia == {m_arb_hi, arb[i]}) return i;
    return -1;
  endfunction

  task automatic set_cfg(input logic [2:0] a, input logic [1:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_arb_hi = a; cfg_vec_hi = v;
    @(negedge clk);
    cfg_we = 1'b0;
    m_arb_hi = a; m_vec_hi = v;
  endtask

  task automatic do_ack(input string tag, input logic v, input logic [2:0] l, input logic [3:0] a);
    int w;
    logic [6:0] el;
    @(negedge clk);
    iv = v; il = l; ia = a;
    w = exp_win();
    el = exp_lines();
    @(negedge clk);
    iv = 1'b0;
    chk({tag, " R2 lines"}, 32'(lines), 32'(el));
    chk({tag, " R4 R9 hit"}, 32'(hit), 32'(w >= 0));
    if (w >= 0) begin
      chk({tag, " R5 R6 vector"}, 32'(vec), 32'({m_vec_hi, 6'(w)}));
      chk({tag, " R7 ack"}, 32'(ack), 32'(13'd1 << w));
    end else begin
      chk({tag, " R7 idle vector"}, 32'(vec), 32'd0);
      chk({tag, " R7 idle ack"}, 32'(ack), 32'd0);
    end
    @(negedge clk);
    chk({tag, " R9 single cycle"}, 32'(hit), 32'd0);
  endtask

  function automatic void set_lvl(input int i, input logic [2:0] l);
    lvl[i*3 +: 3] = l;
  endfunction

  initial begin
    #(CLK_P * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; pend = '0; arb = '0; lvl = '0; cfg_we = 1'b0;
    cfg_arb_hi = '0; cfg_vec_hi = '0; iv = 1'b0; il = '0; ia = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset lines", 32'(lines), 0);
    chk("R1 reset hit", 32'(hit), 0);
    chk("R1 reset ack", 32'(ack), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset vector", 32'(vec), 0);

    // R8: zero arbitration field, source with bit 1 would match arb 1
    pend = 13'h0010; set_lvl(4, 3'd5); arb[4] = 1'b1;
    do_ack("R8 zero cfg", 1'b1, 3'd5, 4'd1);
    chk("R8 no hit", 32'(hit), 0);

    // R3: write config, then single hit
    set_cfg(3'd5, 2'b10);
    do_ack("R3 single", 1'b1, 3'd5, {3'd5, 1'b1});
    do_ack("R4 wrong arb bit", 1'b1, 3'd5, {3'd5, 1'b0});
    do_ack("R4 wrong level", 1'b1, 3'd4, {3'd5, 1'b1});
    do_ack("R9 no strobe", 1'b0, 3'd5, {3'd5, 1'b1});

    // R5: tie, lowest wins
    pend = 13'h1A10; arb = '1;
    set_lvl(9, 3'd5); set_lvl(11, 3'd5); set_lvl(12, 3'd5);
    do_ack("R5 tie", 1'b1, 3'd5, {3'd5, 1'b1});

    // R2: sources 0 and 1 never request; level 0 disables
    pend = 13'h0007; lvl = '0;
    set_lvl(0, 3'd3); set_lvl(1, 3'd3); set_lvl(2, 3'd0);
    do_ack("R2 masked", 1'b1, 3'd3, {3'd5, 1'b1});
    do_ack("R2 level zero", 1'b1, 3'd0, {3'd5, 1'b1});

    // R6: vector upper bits follow new config
    set_cfg(3'd7, 2'b11);
    pend = 13'h0008; set_lvl(3, 3'd7); arb[3] = 1'b0;
    do_ack("R6 vec hi", 1'b1, 3'd7, {3'd7, 1'b0});

    for (int t = 0; t < 400; t++) begin
      if (t % 40 == 0) set_cfg(3'($urandom), 2'($urandom));
      @(negedge clk);
      pend = N'($urandom); arb = N'($urandom);
      for (int i = 0; i < N; i++) set_lvl(i, 3'($urandom));
      if ($urandom % 2 == 0) begin
        int j = 2 + int'($urandom % 11);
        do_ack("rand aimed", 1'b1, lvl[j*3 +: 3], {m_arb_hi, arb[j]});
      end else begin
        do_ack("rand free", 1'($urandom), 3'($urandom), 4'($urandom));
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule